// File: doc/BRIEF.md
# Out-of-Order DRAM Request Scheduler

The scheduler sits between a source of memory requests and a simple SDRAM command generator. Each request names a bank, a row and a column. It also carries a direction (read or write) and a tag. Accepted requests wait in a small look-ahead queue. Every cycle the block inspects all waiting entries, picks one, and emits the single command that moves that entry forward. The command is an activate, a precharge, a read or a write, and it is only emitted if the bank's timing counters allow it.

Requests are not served first-in first-out. Requests whose row is already open in their bank go first, and reads and writes are batched so that the data bus changes direction rarely. A request that hits an open row may therefore overtake an older one that needs its bank cycled. A per-entry waiting counter bounds how long any request can be passed over. Each bank keeps its open row and its own activate, precharge and access counters. A bus-direction counter enforces idle cycles whenever the data direction changes.

Top module: `dram_ooo_sched`

## Requirements
- R1: After reset `cmd_op` is 0 (no command) and `req_ready` is high; with an empty queue only code 0 is emitted.
- R2: The queue holds up to DEPTH requests; `req_ready` is low exactly when DEPTH requests are held, and a request offered while it is low is dropped and never served.
- R3: Activate (`cmd_op` 1) is issued only to a closed bank, at least TRP cycles after that bank's last precharge, and opens the row given on `cmd_row`.
- R4: Read (`cmd_op` 3) and write (`cmd_op` 4) are issued only to a bank whose open row equals the request's row, at least TRCD cycles after that bank's activate.
- R5: Precharge (`cmd_op` 2) is issued only to an open bank, at least TRAS cycles after its activate, and closes the bank.
- R6: Every accepted request receives exactly one read or write carrying its tag, bank, row and column; direction 0 maps to read and direction 1 to write.
- R7: A data command whose direction differs from the previous data command comes at least TURN+1 cycles after it; same-direction data commands may be back to back.
- R8: Among row hits, a hit in the direction of the last data command is served before an older hit in the other direction.
- R9: A request left waiting for AGE_MAX cycles takes priority over row hits, and its data command appears no later than AGE_MAX+TRAS+TRP+TRCD+TURN+4 cycles after acceptance, but not earlier than AGE_MAX cycles while hits keep arriving.
- R10: A row hit, in either direction, is served before an older request that needs a different row opened in the same bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_ready | output | 1 | Queue has room; request taken when both high |
| req_tag | input | TAG_W | Request identifier |
| req_dir | input | 1 | 0 read, 1 write |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_op | output | 3 | 0 none, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the served entry |
| cmd_col | output | COL_W | Column for read or write |
| cmd_tag | output | TAG_W | Tag for read or write |

## Verification
The bench builds the block with two banks, four rows, an eight-entry queue, five-bit tags and the default timing of TRCD=2, TRP=2, TRAS=5, TURN=2 and AGE_MAX=16. With only two banks and four rows, a long pseudo-random stream produces frequent row hits, row conflicts and direction changes, so every timing rule and the exactly-once service rule are exercised against a command-stream model. The short aging limit makes starvation reachable within a few dozen cycles, and the small queue makes the full condition easy to reach.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_PRE = 3'd2,
      CMD_RD  = 3'd3,
      CMD_WR  = 3'd4
   } cmd_e;

endpackage

// File: rtl/dram_sched_bank.sv
// Per-bank state: open row register and the three timing down-counters.
module dram_sched_bank #(
   parameter int ROW_W = 4,
   parameter int TRCD  = 2,
   parameter int TRP   = 2,
   parameter int TRAS  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_pre,
   input  logic [ROW_W-1:0] act_row,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q,
   output logic             act_ok,
   output logic             pre_ok,
   output logic             acc_ok
);
   localparam int MAX_A = (TRCD > TRP) ? TRCD : TRP;
   localparam int MAXT  = (MAX_A > TRAS) ? MAX_A : TRAS;
   localparam int CW    = $clog2(MAXT + 1);

   logic [CW-1:0] rcd_q, rp_q, ras_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
         rcd_q   <= '0;
         rp_q    <= '0;
         ras_q   <= '0;
      end else begin
         if (do_act) begin
            is_open <= 1'b1;
            row_q   <= act_row;
            rcd_q   <= CW'(TRCD - 1);
            ras_q   <= CW'(TRAS - 1);
         end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - CW'(1);
            if (ras_q != '0) ras_q <= ras_q - CW'(1);
         end
         if (do_pre) begin
            is_open <= 1'b0;
            rp_q    <= CW'(TRP - 1);
         end else if (rp_q != '0) begin
            rp_q <= rp_q - CW'(1);
         end
      end
   end

   assign act_ok = !is_open && (rp_q == '0);
   assign pre_ok = is_open && (ras_q == '0);
   assign acc_ok = is_open && (rcd_q == '0);

endmodule

// File: rtl/dram_sched_pick.sv
// Entry selection: aged first, then same-direction hit, other-direction hit, oldest.
// Lower index means older.
module dram_sched_pick #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3
) (
   input  logic [DEPTH-1:0] vld,
   input  logic [DEPTH-1:0] hit,
   input  logic [DEPTH-1:0] dirv,
   input  logic [DEPTH-1:0] aged,
   input  logic             cur_dir,
   output logic [IDX_W-1:0] sel,
   output logic             any
);
   logic [DEPTH-1:0] c_age, c_same, c_other;

   function automatic logic [IDX_W-1:0] first_set(input logic [DEPTH-1:0] v);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (v[i]) r = IDX_W'(i);
      end
      return r;
   endfunction

   assign c_age   = vld & aged;
   assign c_same  = vld & hit & ~(dirv ^ {DEPTH{cur_dir}});
   assign c_other = vld & hit;
   assign any     = |vld;

   always_comb begin
      if (|c_age)        sel = first_set(c_age);
      else if (|c_same)  sel = first_set(c_same);
      else if (|c_other) sel = first_set(c_other);
      else               sel = first_set(vld);
   end

endmodule

// File: rtl/dram_ooo_sched.sv
module dram_ooo_sched
   import dram_sched_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int BANK_W  = 2,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 4,
   parameter int TAG_W   = 4,
   parameter int TRCD    = 2,
   parameter int TRP     = 2,
   parameter int TRAS    = 5,
   parameter int TURN    = 2,
   parameter int AGE_MAX = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              req_dir,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic [2:0]        cmd_op,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [TAG_W-1:0]  cmd_tag
);
   localparam int BANKS = 1 << BANK_W;
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int AGE_W = $clog2(AGE_MAX + 1);
   localparam int TRN_W = $clog2(TURN + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dram_ooo_sched: DEPTH must be at least 2");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("dram_ooo_sched: BANK_W must be at least 1");
   end
   if (TRCD < 1 || TRP < 1 || TRAS < 1) begin : g_bad_timing
      $error("dram_ooo_sched: bank timings must be at least 1");
   end
   if (TURN < 1 || AGE_MAX < 1) begin : g_bad_turn
      $error("dram_ooo_sched: TURN and AGE_MAX must be at least 1");
   end

   // queue storage, index 0 is the oldest entry
   logic [CNT_W-1:0]  cnt_q;
   logic [TAG_W-1:0]  q_tag  [DEPTH];
   logic              q_dir  [DEPTH];
   logic [BANK_W-1:0] q_bank [DEPTH];
   logic [ROW_W-1:0]  q_row  [DEPTH];
   logic [COL_W-1:0]  q_col  [DEPTH];
   logic [AGE_W-1:0]  q_age  [DEPTH];
   logic [TAG_W-1:0]  n_tag  [DEPTH];
   logic              n_dir  [DEPTH];
   logic [BANK_W-1:0] n_bank [DEPTH];
   logic [ROW_W-1:0]  n_row  [DEPTH];
   logic [COL_W-1:0]  n_col  [DEPTH];
   logic [AGE_W-1:0]  n_age  [DEPTH];

   logic [DEPTH-1:0]  q_vld, hit, aged, dirv;
   logic [IDX_W-1:0]  sel;
   logic              any;
   logic [BANKS-1:0]  open_vld, act_ok, pre_ok, acc_ok;
   logic [BANKS-1:0][ROW_W-1:0] open_row;
   cmd_e              iss_op;
   logic              take, accept;
   logic              cur_dir;
   logic [TRN_W-1:0]  turn_q;
   logic [BANK_W-1:0] sb;
   logic [CNT_W-1:0]  wr_idx;

   assign req_ready = (cnt_q < CNT_W'(DEPTH));
   assign accept    = req_valid && req_ready;
   assign sb        = q_bank[sel];
   assign wr_idx    = cnt_q - CNT_W'(take);

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         q_vld[i] = (CNT_W'(i) < cnt_q);
         hit[i]   = open_vld[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
         aged[i]  = (q_age[i] == AGE_W'(AGE_MAX));
         dirv[i]  = q_dir[i];
      end
   end

   dram_sched_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
      .vld(q_vld), .hit(hit), .dirv(dirv), .aged(aged),
      .cur_dir(cur_dir), .sel(sel), .any(any)
   );

   // command for the selected entry, gated by bank and bus timing
   always_comb begin
      iss_op = CMD_NOP;
      take   = 1'b0;
      if (any) begin
         if (hit[sel]) begin
            if (acc_ok[sb] && ((q_dir[sel] == cur_dir) || (turn_q == '0))) begin
               iss_op = q_dir[sel] ? CMD_WR : CMD_RD;
               take   = 1'b1;
            end
         end else if (open_vld[sb]) begin
            if (pre_ok[sb]) iss_op = CMD_PRE;
         end else if (act_ok[sb]) begin
            iss_op = CMD_ACT;
         end
      end
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      dram_sched_bank #(.ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .do_act  ((iss_op == CMD_ACT) && (sb == BANK_W'(b))),
         .do_pre  ((iss_op == CMD_PRE) && (sb == BANK_W'(b))),
         .act_row (q_row[sel]),
         .is_open (open_vld[b]),
         .row_q   (open_row[b]),
         .act_ok  (act_ok[b]),
         .pre_ok  (pre_ok[b]),
         .acc_ok  (acc_ok[b])
      );
   end

   // compaction on removal, append on accept, aging of every entry
   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         int j;
         j = (take && (i >= int'(sel)) && (i < DEPTH - 1)) ? i + 1 : i;
         n_tag[i]  = q_tag[j];
         n_dir[i]  = q_dir[j];
         n_bank[i] = q_bank[j];
         n_row[i]  = q_row[j];
         n_col[i]  = q_col[j];
         n_age[i]  = (q_age[j] == AGE_W'(AGE_MAX)) ? q_age[j] : q_age[j] + AGE_W'(1);
         if (accept && (CNT_W'(i) == wr_idx)) begin
            n_tag[i]  = req_tag;
            n_dir[i]  = req_dir;
            n_bank[i] = req_bank;
            n_row[i]  = req_row;
            n_col[i]  = req_col;
            n_age[i]  = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         cur_dir  <= 1'b0;
         turn_q   <= '0;
         cmd_op   <= CMD_NOP;
         cmd_bank <= '0;
         cmd_row  <= '0;
         cmd_col  <= '0;
         cmd_tag  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            q_tag[i]  <= '0;
            q_dir[i]  <= 1'b0;
            q_bank[i] <= '0;
            q_row[i]  <= '0;
            q_col[i]  <= '0;
            q_age[i]  <= '0;
         end
      end else begin
         cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(take);
         for (int i = 0; i < DEPTH; i++) begin
            q_tag[i]  <= n_tag[i];
            q_dir[i]  <= n_dir[i];
            q_bank[i] <= n_bank[i];
            q_row[i]  <= n_row[i];
            q_col[i]  <= n_col[i];
            q_age[i]  <= n_age[i];
         end
         if (take) begin
            cur_dir <= q_dir[sel];
            turn_q  <= TRN_W'(TURN);
         end else if (turn_q != '0) begin
            turn_q <= turn_q - TRN_W'(1);
         end
         cmd_op   <= iss_op;
         cmd_bank <= sb;
         cmd_row  <= q_row[sel];
         cmd_col  <= q_col[sel];
         cmd_tag  <= q_tag[sel];
      end
   end

endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk #(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 4
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic [2:0]                          cmd_op,
   input logic [2:0]                          iss_op,
   input logic [BANK_W-1:0]                   iss_bank,
   input logic [ROW_W-1:0]                    iss_row,
   input logic [(1<<BANK_W)-1:0]              open_vld,
   input logic [(1<<BANK_W)-1:0][ROW_W-1:0]   open_row,
   input logic [$clog2(DEPTH+1)-1:0]          cnt
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   // R2: occupancy never exceeds the queue depth
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));

   // R3: activate targets a closed bank and opens the requested row
   p_act_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_op == 3'd1) |-> !open_vld[iss_bank]);

   p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_op == 3'd1) |=> (open_vld[$past(iss_bank)] &&
                            (open_row[$past(iss_bank)] == $past(iss_row))));

   // R5: precharge closes its bank
   p_pre_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_op == 3'd2) |=> !open_vld[$past(iss_bank)]);

   // R4: data access only on the open row of its bank
   p_acc_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((iss_op == 3'd3) || (iss_op == 3'd4)) |->
         (open_vld[iss_bank] && (open_row[iss_bank] == iss_row)));

   // R7: no direction change on adjacent cycles of the data command stream
   p_turn_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd3) |=> (cmd_op != 3'd4));

   p_turn_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd4) |=> (cmd_op != 3'd3));

endmodule

bind dram_ooo_sched dram_sched_chk #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_op   (cmd_op),
   .iss_op   (iss_op),
   .iss_bank (sb),
   .iss_row  (q_row[sel]),
   .open_vld (open_vld),
   .open_row (open_row),
   .cnt      (cnt_q)
);

// File: tb/sim_dram_ooo_sched.sv
module sim_dram_ooo_sched;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH   = 8;
   localparam int BANK_W  = 1;
   localparam int BANKS   = 2;
   localparam int ROW_W   = 2;
   localparam int COL_W   = 3;
   localparam int TAG_W   = 5;
   localparam int TRCD    = 2;
   localparam int TRP     = 2;
   localparam int TRAS    = 5;
   localparam int TURN    = 2;
   localparam int AGE_MAX = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [TAG_W-1:0]  req_tag = '0;
   logic              req_dir = 1'b0;
   logic [BANK_W-1:0] req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic [2:0]        cmd_op;
   logic [BANK_W-1:0] cmd_bank;
   logic [ROW_W-1:0]  cmd_row;
   logic [COL_W-1:0]  cmd_col;
   logic [TAG_W-1:0]  cmd_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_ooo_sched #(
      .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
      .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TURN(TURN), .AGE_MAX(AGE_MAX)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_tag(req_tag), .req_dir(req_dir), .req_bank(req_bank), .req_row(req_row),
      .req_col(req_col), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
      .cmd_col(cmd_col), .cmd_tag(cmd_tag)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   // bench model of requests and banks, fed only by ports
   bit pend [32];
   bit p_dir [32];
   int p_bank [32], p_row [32], p_col [32], p_cyc [32];
   int inflight;
   int b_open [BANKS], b_row [BANKS], last_act [BANKS], last_pre [BANKS];
   int last_dcyc, last_ddir;
   int srv_tag [4096];
   int srv_cyc [4096];
   int n_srv;
   bit poke_full, poked, bad_seen;

   always @(posedge clk) cyc++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int t = 0; t < 32; t++) pend[t] = 0;
      for (int b = 0; b < BANKS; b++) begin
         b_open[b] = 0; b_row[b] = 0; last_act[b] = -1000; last_pre[b] = -1000;
      end
      inflight = 0; last_dcyc = -1000; last_ddir = -1; n_srv = 0;
      poke_full = 0; poked = 0; bad_seen = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      clear_model();
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_op == 3'd0, "R1 reset cmd_op", int'(cmd_op), 0);
      check(req_ready == 1'b1, "R1 reset req_ready", int'(req_ready), 1);
   endtask

   task automatic push(input int tag, input bit dir, input int bank, input int row, input int col);
      @(negedge clk);
      while (!req_ready) begin
         if (poke_full && !poked) begin
            req_valid = 1'b1;
            req_tag = TAG_W'(30);
            poked = 1;
         end
         @(negedge clk);
         req_valid = 1'b0;
      end
      req_valid = 1'b1;
      req_tag = TAG_W'(tag); req_dir = dir; req_bank = BANK_W'(bank);
      req_row = ROW_W'(row); req_col = COL_W'(col);
      @(posedge clk);
      pend[tag] = 1; p_dir[tag] = dir; p_bank[tag] = bank; p_row[tag] = row; p_col[tag] = col;
      inflight++;
      #1;
      p_cyc[tag] = cyc;
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 3000 && inflight != 0; k++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   function automatic int pos_of(input int tag);
      for (int k = 0; k < n_srv; k++) if (srv_tag[k] == tag) return k;
      return -1;
   endfunction

   // command stream monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int b, t;
         b = int'(cmd_bank);
         t = int'(cmd_tag);
         case (cmd_op)
            3'd0: ;
            3'd1: begin
               check(b_open[b] == 0, "R3 activate on closed bank", b_open[b], 0);
               check(cyc - last_pre[b] >= TRP, "R3 tRP spacing", cyc - last_pre[b], TRP);
               b_open[b] = 1; b_row[b] = int'(cmd_row); last_act[b] = cyc;
            end
            3'd2: begin
               check(b_open[b] == 1, "R5 precharge on open bank", b_open[b], 1);
               check(cyc - last_act[b] >= TRAS, "R5 tRAS spacing", cyc - last_act[b], TRAS);
               b_open[b] = 0; last_pre[b] = cyc;
            end
            3'd3, 3'd4: begin
               int d;
               d = (cmd_op == 3'd4) ? 1 : 0;
               if (t == 30) bad_seen = 1;
               check(pend[t], "R6 tag pending when served", t, t);
               check(pend[t] && p_dir[t] == d && p_bank[t] == b && p_row[t] == int'(cmd_row)
                     && p_col[t] == int'(cmd_col), "R6 served fields", int'(cmd_col), p_col[t]);
               check(b_open[b] == 1 && b_row[b] == int'(cmd_row), "R4 access on open row",
                     b_row[b], int'(cmd_row));
               check(cyc - last_act[b] >= TRCD, "R4 tRCD spacing", cyc - last_act[b], TRCD);
               if (last_ddir >= 0 && last_ddir != d)
                  check(cyc - last_dcyc > TURN, "R7 turnaround gap", cyc - last_dcyc, TURN + 1);
               last_ddir = d; last_dcyc = cyc;
               if (pend[t]) begin
                  pend[t] = 0;
                  inflight--;
               end
               srv_tag[n_srv] = t; srv_cyc[n_srv] = cyc; n_srv++;
            end
            default: check(1'b0, "R6 legal opcode", int'(cmd_op), 0);
         endcase
         check((req_ready == 1'b0) == (inflight == DEPTH), "R2 ready versus occupancy",
               int'(req_ready), (inflight == DEPTH) ? 0 : 1);
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int pa, pb, idx;
      logic [15:0] lfsr;

      clear_model();
      // R1: reset state and idle behaviour
      do_reset();
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(cmd_op == 3'd0, "R1 idle emits no command", int'(cmd_op), 0);
      end

      // R10: hit in the other direction passes an older row miss
      do_reset();
      push(1, 0, 0, 1, 1);
      push(2, 0, 0, 2, 2);
      push(3, 1, 0, 1, 3);
      wait_idle();
      pa = pos_of(3); pb = pos_of(2);
      check(pa >= 0 && pb >= 0 && pa < pb, "R10 hit before older miss", pa, pb);
      check(inflight == 0, "R6 all served scenario hit", inflight, 0);

      // R8: same-direction hit before older other-direction hit
      do_reset();
      push(4, 0, 0, 1, 4);
      push(5, 1, 0, 1, 5);
      push(6, 0, 0, 1, 6);
      wait_idle();
      pa = pos_of(6); pb = pos_of(5);
      check(pa >= 0 && pb >= 0 && pa < pb, "R8 same direction first", pa, pb);

      // R9: aging forces an old miss through a stream of hits
      do_reset();
      push(0, 0, 0, 1, 0);
      push(31, 0, 0, 2, 7);
      for (int k = 0; k < 40; k++) push(1 + (k % 15), 0, 0, 1, k % 8);
      wait_idle();
      idx = pos_of(31);
      check(idx > 1, "R9 miss bypassed by hits", idx, 2);
      if (idx >= 0) begin
         check(srv_cyc[idx] - p_cyc[31] <= AGE_MAX + TRAS + TRP + TRCD + TURN + 4,
               "R9 aged request latency bound", srv_cyc[idx] - p_cyc[31],
               AGE_MAX + TRAS + TRP + TRCD + TURN + 4);
         check(srv_cyc[idx] - p_cyc[31] >= AGE_MAX, "R9 not served before aging",
               srv_cyc[idx] - p_cyc[31], AGE_MAX);
      end

      // R2: fill the queue with conflicting rows, offer one while full
      do_reset();
      poke_full = 1;
      for (int k = 0; k < 12; k++) push(8 + k, 0, 1, k % 4, k % 8);
      poke_full = 0;
      wait_idle();
      check(poked == 1, "R2 full condition reached", int'(poked), 1);
      check(bad_seen == 0, "R2 request offered while full dropped", int'(bad_seen), 0);
      check(inflight == 0, "R6 all served scenario fill", inflight, 0);

      // pseudo-random sweep over mixed traffic
      do_reset();
      lfsr = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
         int tg;
         tg = k % 30;
         for (int w = 0; w < 100 && pend[tg]; w++) @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         push(tg, lfsr[0], int'(lfsr[1]), int'(lfsr[3:2]), int'(lfsr[6:4]));
         if (lfsr[9] && lfsr[8]) @(negedge clk);
      end
      wait_idle();
      check(inflight == 0, "R6 every random request served", inflight, 0);
      check(n_srv == 600, "R6 exactly one service each", n_srv, 600);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule